// File: doc/BRIEF.md
# Banked Command and Interrupt Controller

This block is the command and status port of a network adapter's host register bank. Hosts write 16-bit command words to one shared offset, which is decoded the same way whichever register window is active. Reads of that offset return a status word. The status word carries the active window number, a busy flag and a byte of latched event bits.

Commands select the register window and turn the receiver and transmitter on or off. They also reset those paths or the whole block, load an interrupt mask, raise a software interrupt request and acknowledge events. Event pulses from the datapath are latched here. A single interrupt output is driven from the events that are both latched and unmasked. Reset commands hold a busy flag for a parameterised number of cycles, which stands in for the real recovery delays. Commands written while the flag is high are dropped.

Top module: `nic_cmd_ctrl`

## Requirements
- R1: After rst_ni is released, status_o is 0, window_o is 0, irq_o is 0, and rx_en_o, tx_en_o, rx_rst_o and tx_rst_o are all 0.
- R2: A command word carries its opcode in bits 15:11 and its argument in bits 10:0. A write whose opcode is 2, 6, 7, 8 or 15 to 31 changes no output and no state.
- R3: Opcode 1 loads argument bits 2:0 into the active window. The new window shows on window_o and on status bits 15:13 in the cycle after the write.
- R4: Opcode 4 enables the receiver and opcode 3 disables it. Opcode 9 enables the transmitter and opcode 10 disables it. Each takes effect on rx_en_o or tx_en_o one cycle after the write.
- R5: Opcode 13 clears each status bit 7:0 whose argument bit is set. A bit whose event arrives in the same cycle stays set.
- R6: Opcode 14 loads argument bits 7:0 as the interrupt mask. irq_o is high exactly when some status bit from 1 to 7 is set and its mask bit is set.
- R7: Opcode 12 sets status bit 6 (interrupt requested).
- R8: Status bit 0 (interrupt latch) sets at the clock edge that ends the first cycle in which irq_o is high after being low.
- R9: evt_i bits 1 to 5 and 7 set the matching status bits at the next edge: 1 adapter failure, 2 TX complete, 3 TX available, 4 RX complete, 5 RX early, 7 statistics update. evt_i bits 0 and 6 are ignored.
- R10: Opcode 0 (global reset) clears the window, the mask, all events and both enables. It pulses rx_rst_o and tx_rst_o high for one cycle. It holds busy for GLB_BUSY_CYCLES cycles. It wins over any event set in the same cycle.
- R11: Opcode 5 pulses rx_rst_o and opcode 11 pulses tx_rst_o, each for the one cycle after the write. Each also clears its own enable and holds busy for BLK_BUSY_CYCLES cycles.
- R12: Status bit 12 shows busy. Writes made while busy is high are ignored. Status bits 11:8 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Command write strobe |
| wr_data_i | input | 16 | Command word |
| evt_i | input | 8 | Event set pulses from the datapath |
| status_o | output | 16 | Status word |
| window_o | output | 3 | Active register window |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receiver enabled |
| tx_en_o | output | 1 | Transmitter enabled |
| rx_rst_o | output | 1 | Receive path reset pulse |
| tx_rst_o | output | 1 | Transmit path reset pulse |

## Verification
The hardest cases to reach from the ports come from timing collisions. One is an acknowledge that lands in the same cycle as a fresh event on the same bit. Another is a write that arrives in the last cycle of a busy window. A third is an interrupt that rises in the same cycle as a global reset. The stimulus covers these with a long random phase after the directed checks. In that phase event pulses are sparse, writes come about every other cycle, and resets are rare, so busy windows open and close often and collisions occur many times. A behavioural model updates on every clock and flags any output difference.

// File: rtl/nic_cmd_pkg.sv
`timescale 1ns/1ps
package nic_cmd_pkg;
  localparam int CMD_W  = 16;
  localparam int OP_W   = 5;
  localparam int EV_W   = 8;
  localparam int WIN_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_GLB_RST  = 5'd0,
    OP_WIN_SEL  = 5'd1,
    OP_RX_OFF   = 5'd3,
    OP_RX_ON    = 5'd4,
    OP_RX_RST   = 5'd5,
    OP_TX_ON    = 5'd9,
    OP_TX_OFF   = 5'd10,
    OP_TX_RST   = 5'd11,
    OP_REQ_IRQ  = 5'd12,
    OP_ACK      = 5'd13,
    OP_SET_MASK = 5'd14
  } opcode_e;

  // status event bit positions
  localparam int EV_LATCH = 0;
  localparam int EV_REQ   = 6;
  // events the datapath may set directly
  localparam logic [EV_W-1:0] EXT_EVT_MASK = 8'hBE;

  typedef struct packed {
    logic            glb_rst;
    logic            win_sel;
    logic            rx_off;
    logic            rx_on;
    logic            rx_rst;
    logic            tx_on;
    logic            tx_off;
    logic            tx_rst;
    logic            req_irq;
    logic            ack;
    logic            set_mask;
    logic [EV_W-1:0] arg;
  } cmd_t;
endpackage

// File: rtl/nic_cmd_decode.sv
`timescale 1ns/1ps
module nic_cmd_decode
  import nic_cmd_pkg::*;
(
  input  logic             valid_i,
  input  logic [CMD_W-1:0] data_i,
  output cmd_t             cmd_o
);
  logic [OP_W-1:0] op;
  logic            unused_hi_arg;

  assign op            = data_i[CMD_W-1 -: OP_W];
  assign unused_hi_arg = ^data_i[CMD_W-OP_W-1:EV_W];

  always_comb begin
    cmd_o     = '0;
    cmd_o.arg = data_i[EV_W-1:0];
    if (valid_i) begin
      unique case (op)
        OP_GLB_RST:  cmd_o.glb_rst  = 1'b1;
        OP_WIN_SEL:  cmd_o.win_sel  = 1'b1;
        OP_RX_OFF:   cmd_o.rx_off   = 1'b1;
        OP_RX_ON:    cmd_o.rx_on    = 1'b1;
        OP_RX_RST:   cmd_o.rx_rst   = 1'b1;
        OP_TX_ON:    cmd_o.tx_on    = 1'b1;
        OP_TX_OFF:   cmd_o.tx_off   = 1'b1;
        OP_TX_RST:   cmd_o.tx_rst   = 1'b1;
        OP_REQ_IRQ:  cmd_o.req_irq  = 1'b1;
        OP_ACK:      cmd_o.ack      = 1'b1;
        OP_SET_MASK: cmd_o.set_mask = 1'b1;
        default: ;  // unknown opcodes are accepted and do nothing
      endcase
    end
  end
endmodule

// File: rtl/nic_busy_timer.sv
`timescale 1ns/1ps
module nic_busy_timer #(
  parameter int GLB_CYCLES = 64,
  parameter int BLK_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_glb_i,
  input  logic start_blk_i,
  output logic busy_o
);
  localparam int MAX_CYC = (GLB_CYCLES > BLK_CYCLES) ? GLB_CYCLES : BLK_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_glb_i) cnt_q <= CNT_W'(GLB_CYCLES);
    else if (start_blk_i) cnt_q <= CNT_W'(BLK_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R10 / R11: a reset command opens a busy window
  a_r11_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_glb_i || start_blk_i) |=> busy_o);
  // R12: busy only rises because of a reset command
  a_r12_busy_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_glb_i || start_blk_i));
endmodule

// File: rtl/nic_event_bank.sv
`timescale 1ns/1ps
module nic_event_bank
  import nic_cmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            glb_clr_i,
  input  logic            ack_i,
  input  logic [EV_W-1:0] ack_mask_i,
  input  logic            req_i,
  input  logic            mask_ld_i,
  input  logic [EV_W-1:0] mask_i,
  input  logic [EV_W-1:0] evt_i,
  output logic [EV_W-1:0] events_o,
  output logic            irq_o
);
  logic [EV_W-1:0] ev_q, mask_q, set_v, clr_v;
  logic            irq_q;

  assign irq_o = |(ev_q[EV_W-1:1] & mask_q[EV_W-1:1]);

  always_comb begin
    set_v           = evt_i & EXT_EVT_MASK;
    set_v[EV_REQ]   = set_v[EV_REQ] | req_i;
    set_v[EV_LATCH] = irq_o & ~irq_q;
    clr_v           = ack_i ? ack_mask_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_o;
      if (glb_clr_i) begin
        ev_q   <= '0;
        mask_q <= '0;
      end else begin
        ev_q <= (ev_q & ~clr_v) | set_v;  // set beats clear
        if (mask_ld_i) mask_q <= mask_i;
      end
    end
  end

  assign events_o = ev_q;

  a_r8_latch_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(irq_o) && !glb_clr_i) |=> events_o[EV_LATCH]);
  a_r10_glb_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_clr_i |=> (events_o == '0 && !irq_o));
  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_mask_i[EV_W-1] && !evt_i[EV_W-1]) |=> !events_o[EV_W-1]);
  a_r9_ext_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[EV_W-1] && !glb_clr_i) |=> events_o[EV_W-1]);
endmodule

// File: rtl/nic_cmd_ctrl.sv
`timescale 1ns/1ps
module nic_cmd_ctrl
  import nic_cmd_pkg::*;
#(
  parameter int GLB_BUSY_CYCLES = 64,
  parameter int BLK_BUSY_CYCLES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic [7:0]  evt_i,
  output logic [15:0] status_o,
  output logic [2:0]  window_o,
  output logic        irq_o,
  output logic        rx_en_o,
  output logic        tx_en_o,
  output logic        rx_rst_o,
  output logic        tx_rst_o
);
  localparam int RSVD_W = CMD_W - WIN_W - 1 - EV_W;

  cmd_t             cmd;
  logic             busy, accept;
  logic [WIN_W-1:0] win_q;
  logic             rx_en_q, tx_en_q, rx_rst_q, tx_rst_q;
  logic [EV_W-1:0]  events;

  assign accept = wr_en_i & ~busy;

  nic_cmd_decode u_decode (
    .valid_i (accept),
    .data_i  (wr_data_i),
    .cmd_o   (cmd)
  );

  nic_busy_timer #(
    .GLB_CYCLES (GLB_BUSY_CYCLES),
    .BLK_CYCLES (BLK_BUSY_CYCLES)
  ) u_busy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_glb_i (cmd.glb_rst),
    .start_blk_i (cmd.rx_rst | cmd.tx_rst),
    .busy_o      (busy)
  );

  nic_event_bank u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .glb_clr_i  (cmd.glb_rst),
    .ack_i      (cmd.ack),
    .ack_mask_i (cmd.arg),
    .req_i      (cmd.req_irq),
    .mask_ld_i  (cmd.set_mask),
    .mask_i     (cmd.arg),
    .evt_i      (evt_i),
    .events_o   (events),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= '0;
      rx_en_q  <= 1'b0;
      tx_en_q  <= 1'b0;
      rx_rst_q <= 1'b0;
      tx_rst_q <= 1'b0;
    end else begin
      rx_rst_q <= cmd.glb_rst | cmd.rx_rst;
      tx_rst_q <= cmd.glb_rst | cmd.tx_rst;
      if (cmd.glb_rst) begin
        win_q   <= '0;
        rx_en_q <= 1'b0;
        tx_en_q <= 1'b0;
      end else begin
        if (cmd.win_sel)               win_q   <= cmd.arg[WIN_W-1:0];
        if (cmd.rx_on)                 rx_en_q <= 1'b1;
        else if (cmd.rx_off | cmd.rx_rst) rx_en_q <= 1'b0;
        if (cmd.tx_on)                 tx_en_q <= 1'b1;
        else if (cmd.tx_off | cmd.tx_rst) tx_en_q <= 1'b0;
      end
    end
  end

  assign window_o = win_q;
  assign rx_en_o  = rx_en_q;
  assign tx_en_o  = tx_en_q;
  assign rx_rst_o = rx_rst_q;
  assign tx_rst_o = tx_rst_q;
  assign status_o = {win_q, busy, {RSVD_W{1'b0}}, events};

  a_r12_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[12] && wr_en_i) |=> ($stable(window_o) && $stable(rx_en_o) && $stable(tx_en_o)));
  a_r3_window_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !status_o[12] && wr_data_i[15:11] == 5'd1) |=> window_o == $past(wr_data_i[2:0]));
  a_r11_rx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !status_o[12] && wr_data_i[15:11] == 5'd5) |=> (rx_rst_o && !rx_en_o));
  a_r10_glb_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !status_o[12] && wr_data_i[15:11] == 5'd0) |=> (rx_rst_o && tx_rst_o && window_o == '0));
endmodule

// File: tb/nic_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module nic_cmd_ctrl_tb_top;
  localparam int GLB = 12;
  localparam int BLK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  evt = '0;
  logic [15:0] status;
  logic [2:0]  window;
  logic        irq, rx_en, tx_en, rx_rst, tx_rst;

  int n_vec = 0;
  int n_fail = 0;
  int cyc = 0;

  // behavioural reference state
  int       m_win, m_busy;
  bit [7:0] m_ev, m_mk;
  bit       m_rx, m_tx, m_rxr, m_txr, m_irqp;

  always #5 clk = ~clk;

  nic_cmd_ctrl #(.GLB_BUSY_CYCLES(GLB), .BLK_BUSY_CYCLES(BLK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .evt_i(evt),
    .status_o(status), .window_o(window), .irq_o(irq), .rx_en_o(rx_en),
    .tx_en_o(tx_en), .rx_rst_o(rx_rst), .tx_rst_o(tx_rst)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_irq();
    return |(m_ev[7:1] & m_mk[7:1]);
  endfunction

  task automatic compare_all();
    cmp("R3 window_o", window, m_win);
    cmp("R3 status window", status[15:13], m_win);
    cmp("R12 status busy", status[12], m_busy != 0);
    cmp("R12 reserved bits", status[11:8], 0);
    cmp("R5 status events", status[7:0], m_ev);
    cmp("R6 irq_o", irq, m_irq());
    cmp("R4 rx_en_o", rx_en, m_rx);
    cmp("R4 tx_en_o", tx_en, m_tx);
    cmp("R11 rx_rst_o", rx_rst, m_rxr);
    cmp("R11 tx_rst_o", tx_rst, m_txr);
  endtask

  // drive one cycle, advance the model, compare at the falling edge
  task automatic step(input bit we, input bit [15:0] d, input bit [7:0] ev);
    bit [4:0] op;
    bit [7:0] arg, clr, set;
    bit       acc, irq_now;
    wr_en = we; wr_data = d; evt = ev;
    @(posedge clk);
    op = d[15:11]; arg = d[7:0];
    acc = we && (m_busy == 0);
    irq_now = m_irq();
    m_rxr = 0; m_txr = 0;
    if (m_busy > 0) m_busy--;
    if (acc && op == 0) begin
      m_ev = 0; m_mk = 0; m_win = 0; m_rx = 0; m_tx = 0;
      m_rxr = 1; m_txr = 1; m_busy = GLB;
    end else begin
      clr = (acc && op == 13) ? arg : 8'h00;
      set = ev & 8'hBE;
      if (acc && op == 12) set[6] = 1;
      if (irq_now && !m_irqp) set[0] = 1;
      m_ev = (m_ev & ~clr) | set;
      if (acc) begin
        case (op)
          1:  m_win = arg[2:0];
          3:  m_rx = 0;
          4:  m_rx = 1;
          5:  begin m_rx = 0; m_rxr = 1; m_busy = BLK; end
          9:  m_tx = 1;
          10: m_tx = 0;
          11: begin m_tx = 0; m_txr = 1; m_busy = BLK; end
          14: m_mk = arg;
          default: ;
        endcase
      end
    end
    m_irqp = irq_now;
    @(negedge clk);
    compare_all();
  endtask

  function automatic bit [15:0] cw(input int op, input int arg);
    return {op[4:0], arg[10:0]};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    bit [15:0] snap;
    m_win = 0; m_busy = 0; m_ev = 0; m_mk = 0;
    m_rx = 0; m_tx = 0; m_rxr = 0; m_txr = 0; m_irqp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    cmp("R1 status", status, 0);
    cmp("R1 outputs", {window, irq, rx_en, tx_en, rx_rst, tx_rst}, 0);
    // R9: bits 0 and 6 of evt_i ignored
    step(0, 0, 8'h41);
    cmp("R9 ignored bits", status[7:0], 0);
    step(0, 0, 8'h10);
    cmp("R9 rx complete set", status[4], 1);
    // R2: unknown opcodes do nothing
    snap = status;
    step(1, cw(2, 11'h7FF), 0);
    step(1, cw(31, 11'h3), 0);
    step(1, cw(7, 11'h5), 0);
    cmp("R2 unknown opcode", status, snap);
    cmp("R2 enables unchanged", {rx_en, tx_en}, 0);
    // R3
    step(1, cw(1, 5), 0);
    cmp("R3 window select", window, 5);
    // R4
    step(1, cw(4, 0), 0);
    step(1, cw(9, 0), 0);
    cmp("R4 rx/tx enabled", {rx_en, tx_en}, 2'b11);
    step(1, cw(10, 0), 0);
    cmp("R4 tx disabled", tx_en, 0);
    // R6 / R8
    step(1, cw(14, 8'h10), 0);
    cmp("R6 irq after mask", irq, 1);
    cmp("R8 latch not yet", status[0], 0);
    step(0, 0, 0);
    cmp("R8 latch set", status[0], 1);
    // R7
    step(1, cw(12, 0), 0);
    cmp("R7 request bit", status[6], 1);
    // R5: ack with simultaneous re-set of bit 4
    step(1, cw(13, 8'h51), 8'h10);
    cmp("R5 set wins over ack", status[7:0], 8'h10);
    step(1, cw(13, 8'h10), 0);
    cmp("R5 ack clears", status[4], 0);
    cmp("R6 irq drops", irq, 0);
    // R11 / R12
    step(1, cw(5, 0), 0);
    cmp("R11 rx_rst pulse", rx_rst, 1);
    cmp("R11 rx disabled", rx_en, 0);
    cmp("R12 busy", status[12], 1);
    step(1, cw(1, 2), 0);
    cmp("R11 pulse one cycle", rx_rst, 0);
    cmp("R12 write ignored", window, 5);
    repeat (BLK) step(0, 0, 0);
    cmp("R12 busy ends", status[12], 0);
    // R10
    step(1, cw(0, 0), 8'hFF);
    cmp("R10 global clears", {status[15:13], status[7:0]}, 0);
    cmp("R10 reset pulses", {rx_rst, tx_rst}, 2'b11);
    repeat (GLB) step(0, 0, 0);
    cmp("R10 busy length", status[12], 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int sel;
      int ops[12] = '{1, 3, 4, 9, 10, 12, 13, 14, 14, 13, 5, 11};
      bit [15:0] d;
      sel = $urandom_range(0, 99);
      if (sel == 0)      d = cw(0, $urandom);
      else if (sel < 5)  d = cw($urandom_range(15, 31), $urandom);
      else               d = cw(ops[$urandom_range(0, 11)], $urandom);
      step($urandom_range(0, 1), d, 8'($urandom & $urandom & $urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule